// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier

This block multiplies two elements of the 4096-element Galois field. Each 12-bit element is handled as a pair of 6-bit digits taken from the 64-element subfield, so the field is built as a quadratic extension of that subfield. The product comes from four subfield multiplications and a few XOR terms. No degree-12 polynomial is reduced. A mode input picks the operation. Plain multiplication takes both operands. Step mode multiplies the first operand by a fixed generator constant, so feeding each result back in walks through the powers of the generator. Subfield mode multiplies only the low 6-bit digits.

Operands enter through a valid/ready handshake and the product leaves through another, with one register stage between them. An operand set is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its product is presented on the next edge. The output holds until `out_ready` is high. A new operand set is accepted only while the output register is empty or is being drained in the same cycle, so back-pressure reaches the input with no extra buffering.

Top module: `gft_mul_top`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: In mode 0, `product` = {H, L}. With a = {ah, al} and b = {bh, bl} (high digit in bits 11:6, low digit in bits 5:0), H = m(ah^al, bh^bl) ^ m(al, bl) and L = m(m(ah, bh), 0x21) ^ m(al, bl), where m is subfield multiplication.
- R3: Subfield multiplication m reduces modulo x^6+x+1. For example, m(0x20, 0x02) = 0x03.
- R4: In mode 0, 0x001 is the multiplicative identity and a zero operand gives a zero product.
- R5: In mode 0, the product does not depend on the order of the operands.
- R6: In mode 1, `opa` = 0 gives 0x001 and any other `opa` gives R2's product of `opa` and 0xE01. `opb` is ignored.
- R7: In mode 2, `product` is m(opa[5:0], opb[5:0]) in bits 5:0 with bits 11:6 zero. Bits 11:6 of both operands are ignored.
- R8: Mode 3 computes the same result as mode 0.
- R9: An operand set accepted on one clock edge has its product presented with `out_valid` high right after that edge. With no input accepted and the output drained, `out_valid` goes low.
- R10: While `out_valid` is high and `out_ready` is low, `product` and `out_valid` hold and `in_ready` is low.
- R11: Starting from 0x001 and applying mode 1 repeatedly visits all 4095 nonzero elements. The sequence first returns to 0x001 after exactly 4095 steps.
- R12: Products leave in the order their operands were accepted, none dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Block can take an operand set this cycle |
| mode | input | 2 | 0 multiply, 1 generator step, 2 subfield multiply, 3 same as 0 |
| opa | input | 12 | First operand |
| opb | input | 12 | Second operand (unused in mode 1) |
| out_valid | output | 1 | Product is presented |
| out_ready | input | 1 | Consumer takes the product this cycle |
| product | output | 12 | Field product |

## Verification
Step mode is the corner most likely to be broken. A design that skipped the zero special case would return zero for a zero input and trap the generator walk at zero. A wrong generator constant or extension constant would shorten the cycle or land on values the reference does not predict. Both show up in the full 4095-step walk. The whole 64x64 subfield table is swept with random high digits, which catches a wrong reduction tap and high bits leaking into subfield mode. Random stalls on the output check that a stalled product holds, that `in_ready` drops, and that no result is lost or repeated. A stage that let in a new operand while stalled would overwrite a product.

// File: rtl/gft_pkg.sv
package gft_pkg;
  typedef enum logic [1:0] {
    GFT_MUL     = 2'd0,
    GFT_STEP    = 2'd1,
    GFT_SUB     = 2'd2,
    GFT_MUL_ALT = 2'd3
  } gft_mode_e;
endpackage

// File: rtl/gft_sub_mul.sv
// Combinational multiplier in GF(2^W). Unrolled shift-and-add: the
// running multiple of b is doubled and reduced once per bit of a.
module gft_sub_mul #(
  parameter int unsigned W = 6,
  parameter logic [W:0]  POLY = 7'h43
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  localparam logic [W-1:0] RED = POLY[W-1:0];

  logic [W-1:0] acc  [W+1];
  logic [W-1:0] mult [W+1];

  assign acc[0]  = '0;
  assign mult[0] = b;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign acc[i+1]  = a[i] ? (acc[i] ^ mult[i]) : acc[i];
    assign mult[i+1] = {mult[i][W-2:0], 1'b0} ^ (mult[i][W-1] ? RED : '0);
  end

  assign p = acc[W];
endmodule

// File: rtl/gft_tower_mul.sv
// Product in GF((2^S)^2) built from four subfield multiplications.
module gft_tower_mul #(
  parameter int unsigned      SUB_W = 6,
  parameter logic [SUB_W:0]   POLY  = 7'h43,
  parameter logic [SUB_W-1:0] EXT_K = 6'h21
) (
  input  logic [2*SUB_W-1:0] a,
  input  logic [2*SUB_W-1:0] b,
  output logic [2*SUB_W-1:0] p
);
  localparam int unsigned FW = 2 * SUB_W;

  logic [SUB_W-1:0] ah, al, bh, bl;
  logic [SUB_W-1:0] p_cross, p_low, p_high, p_scaled;

  assign ah = a[FW-1:SUB_W];
  assign al = a[SUB_W-1:0];
  assign bh = b[FW-1:SUB_W];
  assign bl = b[SUB_W-1:0];

  gft_sub_mul #(.W(SUB_W), .POLY(POLY)) u_cross (.a(ah ^ al), .b(bh ^ bl), .p(p_cross));
  gft_sub_mul #(.W(SUB_W), .POLY(POLY)) u_low   (.a(al),      .b(bl),      .p(p_low));
  gft_sub_mul #(.W(SUB_W), .POLY(POLY)) u_high  (.a(ah),      .b(bh),      .p(p_high));
  gft_sub_mul #(.W(SUB_W), .POLY(POLY)) u_scale (.a(p_high),  .b(EXT_K),   .p(p_scaled));

  assign p = {p_cross ^ p_low, p_scaled ^ p_low};

  // R4: zero absorbs, 1 is the identity
  always_comb begin
    p_zero_r4: assert ((a != '0 && b != '0) || p == '0)
      else $error("zero operand gave nonzero product");
    p_ident_r4: assert (b != FW'(1) || p == a)
      else $error("identity operand changed the other operand");
  end
endmodule

// File: rtl/gft_opsel.sv
// Maps the mode onto multiplier operands and the zero-step override.
module gft_opsel
  import gft_pkg::*;
#(
  parameter int unsigned        SUB_W  = 6,
  parameter logic [2*SUB_W-1:0] STEP_K = 12'hE01
) (
  input  gft_mode_e          mode,
  input  logic [2*SUB_W-1:0] opa,
  input  logic [2*SUB_W-1:0] opb,
  output logic [2*SUB_W-1:0] mul_a,
  output logic [2*SUB_W-1:0] mul_b,
  output logic               force_one
);
  localparam int unsigned FW = 2 * SUB_W;

  always_comb begin
    mul_a     = opa;
    mul_b     = opb;
    force_one = 1'b0;
    unique case (mode)
      GFT_STEP: begin
        mul_b     = STEP_K;
        force_one = (opa == '0);
      end
      GFT_SUB: begin
        mul_a = {{(FW-SUB_W){1'b0}}, opa[SUB_W-1:0]};
        mul_b = {{(FW-SUB_W){1'b0}}, opb[SUB_W-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gft_out_stage.sv
// Single register slice with valid/ready on both sides.
module gft_out_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  p_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid)
    else $error("accepted item not presented next cycle");
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid)
    else $error("output valid without an accepted item");
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("stalled product changed");
endmodule

// File: rtl/gft_mul_top.sv
module gft_mul_top
  import gft_pkg::*;
#(
  parameter int unsigned        SUB_W  = 6,
  parameter logic [SUB_W:0]     POLY   = 7'h43,
  parameter logic [SUB_W-1:0]   EXT_K  = 6'h21,
  parameter logic [2*SUB_W-1:0] STEP_K = 12'hE01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         mode,
  input  logic [2*SUB_W-1:0] opa,
  input  logic [2*SUB_W-1:0] opb,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*SUB_W-1:0] product
);
  localparam int unsigned FW = 2 * SUB_W;

  gft_mode_e      mode_e;
  logic [FW-1:0]  mul_a, mul_b, mul_p, result;
  logic           force_one;

  assign mode_e = gft_mode_e'(mode);

  gft_opsel #(.SUB_W(SUB_W), .STEP_K(STEP_K)) u_opsel (
    .mode(mode_e), .opa(opa), .opb(opb),
    .mul_a(mul_a), .mul_b(mul_b), .force_one(force_one)
  );

  gft_tower_mul #(.SUB_W(SUB_W), .POLY(POLY), .EXT_K(EXT_K)) u_mul (
    .a(mul_a), .b(mul_b), .p(mul_p)
  );

  assign result = force_one ? FW'(1) : mul_p;

  gft_out_stage #(.W(FW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(result),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(product)
  );

  // R6: a step never yields zero
  p_step_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode == GFT_STEP |=> product != '0)
    else $error("generator step produced zero");
  // R7: subfield results have an empty high digit
  p_sub_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode == GFT_SUB |=> product[FW-1:SUB_W] == '0)
    else $error("subfield product has high bits set");
endmodule

// File: tb/gft_mul_top_tb_top.sv
`timescale 1ns/1ps
module gft_mul_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  mode = 2'd0;
  logic [11:0] opa = '0;
  logic [11:0] opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] product;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit bp_en  = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gft_mul_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .opa(opa), .opb(opb), .out_valid(out_valid),
    .out_ready(out_ready), .product(product)
  );

  // Independent bit-serial references (Horner order, MSB first)
  function automatic logic [5:0] r64(input logic [5:0] a, input logic [5:0] b);
    logic [5:0] r, t;
    r = '0;
    for (int i = 5; i >= 0; i--) begin
      t = {r[4:0], 1'b0} ^ (r[5] ? 6'h03 : 6'h00);
      r = t ^ (b[i] ? a : 6'h00);
    end
    return r;
  endfunction

  function automatic logic [11:0] r4096(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] h, l, lo;
    lo = r64(a[5:0], b[5:0]);
    h  = r64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo;
    l  = r64(r64(a[11:6], b[11:6]), 6'h21) ^ lo;
    return {h, l};
  endfunction

  function automatic logic [11:0] rstep(input logic [11:0] x);
    return (x == '0) ? 12'h001 : r4096(x, 12'hE01);
  endfunction

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic [11:0] a, input logic [11:0] b,
                      input logic [11:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; mode = m; opa = a; opb = b;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Downstream readiness, changed just after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    out_ready = bp_en ? ($urandom_range(3) != 0) : 1'b1;
  end

  // Monitor / scoreboard
  bit          prev_stall = 0;
  logic [11:0] prev_data  = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && product == prev_data, "R10 hold", product, prev_data);
      if (out_valid && !out_ready)
        check(!in_ready, "R10 in_ready low while stalled", {11'd0, in_ready}, 12'h000);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12 unexpected output", product, 12'h000);
        end else begin
          logic [11:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(product == e, t, product, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = product;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] a, b, x;
    bit          seen [4096];
    int          first_ret, distinct;

    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", {10'd0, out_valid, in_ready}, 12'h001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", {10'd0, out_valid, in_ready}, 12'h001);

    // R9: single item, one-cycle latency, no back-pressure
    send(2'd0, 12'h123, 12'h456, r4096(12'h123, 12'h456), "R9 latency value");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid, "R9 valid one cycle later", {11'd0, out_valid}, 12'h001);
    @(negedge clk);
    check(!out_valid, "R9 valid drops when idle", {11'd0, out_valid}, 12'h000);

    // R3 directed subfield reduction
    send(2'd2, 12'h020, 12'h002, 12'h003, "R3 x^5*x reduces to x+1");
    // R4 identity and zero
    send(2'd0, 12'hABC, 12'h001, 12'hABC, "R4 identity right");
    send(2'd0, 12'h001, 12'h5A5, 12'h5A5, "R4 identity left");
    send(2'd0, 12'h000, 12'hFFF, 12'h000, "R4 zero operand");
    send(2'd0, 12'h7E3, 12'h000, 12'h000, "R4 zero operand b");
    // R6 zero step
    send(2'd1, 12'h000, 12'h9F1, 12'h001, "R6 step of zero");
    idle_drain();

    bp_en = 1;
    // R2 and R5 random multiplication, both operand orders
    for (int i = 0; i < 400; i++) begin
      a = 12'($urandom); b = 12'($urandom);
      send(2'd0, a, b, r4096(a, b), "R2 random product");
      send(2'd0, b, a, r4096(a, b), "R5 swapped operands");
    end
    // R8 alternate code
    for (int i = 0; i < 100; i++) begin
      a = 12'($urandom); b = 12'($urandom);
      send(2'd3, a, b, r4096(a, b), "R8 mode 3 equals mode 0");
    end
    // R7 full subfield table with random high digits
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        a = {6'($urandom), 6'(i)};
        b = {6'($urandom), 6'(j)};
        send(2'd2, a, b, {6'd0, r64(6'(i), 6'(j))}, "R7 subfield table");
      end
    end
    // R6/R11 generator walk with random ignored opb
    foreach (seen[k]) seen[k] = 1'b0;
    x = 12'h001; first_ret = 0; distinct = 0;
    for (int k = 1; k <= 4095; k++) begin
      send(2'd1, x, 12'($urandom), rstep(x), "R11 generator step");
      x = rstep(x);
      if (!seen[x]) distinct++;
      seen[x] = 1'b1;
      if (x == 12'h001 && first_ret == 0) first_ret = k;
    end
    idle_drain();
    check(first_ret == 4095, "R11 period", 12'(first_ret), 12'hFFF);
    check(distinct == 4095 && !seen[0], "R11 distinct nonzero", 12'(distinct), 12'hFFF);
    check(exp_q.size() == 0, "R12 nothing outstanding", 12'(exp_q.size()), 12'h000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule